// File: doc/BRIEF.md
# Framed SPI Command Front End

This block is the serial entry point of a digitally controlled resistor. A host drives a frame-sync line (active low), a serial clock that idles low, and a data line. Bits are taken on the falling clock edge while sync is low. When sync returns high, the block checks whether the burst was a whole number of 16-bit frames. If it was, the last 16 bits go to the command logic as one word, flagged for one cycle. A short burst, or one that ends part way through a frame, is dropped without any notice.

The same shift register drives the serial output. The output changes on the rising clock edge and sends out the register's earlier contents, most significant bit first. Devices can therefore be chained, and a 32-bit burst then fills two of them. Between frames the command logic may load a readback value. That value then goes out in the low bits of the next frame. The output is open drain: it pulls low for a 0 and lets go for a 1. Two accepted words in a row, a park word and then a no-operation word, disable the output entirely.

All serial inputs are resynchronised into the system clock with two-flop stages and edge-detected there. The system clock must run at least four times faster than the serial clock.

Top module: `spi_cmd_front`

## Requirements
- R1: After reset, frameValid is 0, frameWord is 0x0000, sdoEnable is 1 and sdoPullLow is 0.
- R2: In a 16-bit frame, the first bit taken on a falling serial-clock edge becomes frameWord[15] and the last becomes frameWord[0]. The word appears with a single-cycle frameValid pulse a few system cycles after sync rises.
- R3: If sync rises after fewer than 16 falling edges, no frameValid pulse is produced and frameWord keeps its previous value.
- R4: A burst of 32 falling edges is accepted, and frameWord holds the last 16 bits. Bursts of 17, 31 or 33 edges are rejected in the same way as R3.
- R5: On each rising serial-clock edge while sync is low, the output takes the current most significant bit of the shift register. Each frame therefore sends out the 16 bits held before it began, and in a 32-bit burst the second 16 output bits equal the first 16 input bits.
- R6: A pulse on rbLoad while sync is high loads {6'b0, rbData}. The next frame then sends 0 for six bits followed by rbData, MSB first.
- R7: A pulse on rbLoad while sync is low has no effect on the bits sent out.
- R8: An accepted 0x8001 followed by an accepted 0x0000 sets sdoEnable to 0. The output stays released through any further 0x0000 frames. The next accepted word other than 0x0000 sets sdoEnable back to 1. If 0x8001 is followed by any other word, the output is not parked.
- R9: Serial-clock and data activity while sync is high causes no shift. sdoPullLow stays constant, and the next frame sends out the unchanged contents.
- R10: sdoPullLow is 1 only when sdoEnable is 1 and the bit being sent is 0. When sdoPullLow is 0, the line reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, idles low |
| syncNIn | input | 1 | Frame sync, active low |
| dinIn | input | 1 | Serial data in |
| rbLoad | input | 1 | Load the readback value into the shift register (honoured while sync is high) |
| rbData | input | 10 | Readback value |
| frameValid | output | 1 | One-cycle strobe for an accepted frame |
| frameWord | output | 16 | Last accepted 16-bit word |
| sdoEnable | output | 1 | Output enabled (0 = parked in high impedance) |
| sdoPullLow | output | 1 | Open-drain pull-down for the serial output |

## Verification
The hardest state to reach is the parked output. It needs two accepted frames in a fixed order, and a rejected or aborted burst between them must not disturb the sequence. The stimulus runs the park sequence directly, and also a near miss (0x8001 followed by another word). Random bursts of many lengths are mixed with forced 0x8001 and 0x0000 words, so that parking and unparking happen again across aborted bursts, 32-bit bursts and readback loads. A readback load pulsed in the middle of a frame, and clock toggling while sync is high, show whether the shift register was touched in the next frame's output bits.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic shiftIn;   // take one data bit (falling serial edge, sync low)
    logic shiftOut;  // advance serial output (rising serial edge, sync low)
    logic capture;   // frame accepted: latch word
    logic loadRb;    // load readback value (sync idle)
  } strobeT;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= RST_VAL;
      else       stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [FRAME_W-1:0] PARK_WORD = 16'h8001,
  parameter logic [FRAME_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               syncNIn,
  input  logic               dinIn,
  input  logic               rbLoad,
  input  logic [FRAME_W-1:0] shiftWord,
  output strobeT             str,
  output logic               dinBit,
  output logic               frameValid,
  output logic               sdoEnable
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic sclkS, syncNS, dinS;
  logic sclkP, syncP;
  logic [CNT_W-1:0] bitCnt;
  logic fullFrame;
  logic armed, parked;
  logic active, sclkRise, sclkFall, syncRise;

  spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({sclkIn, syncNIn, dinIn}),
    .q   ({sclkS, syncNS, dinS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkP <= 1'b0;
      syncP <= 1'b1;
    end else begin
      sclkP <= sclkS;
      syncP <= syncNS;
    end
  end

  assign active   = ~syncNS;
  assign sclkRise = sclkS & ~sclkP;
  assign sclkFall = ~sclkS & sclkP;
  assign syncRise = syncNS & ~syncP;
  assign dinBit   = dinS;

  always_comb begin
    str.shiftIn  = sclkFall & active;
    str.shiftOut = sclkRise & active;
    str.capture  = syncRise & fullFrame & (bitCnt == '0);
    str.loadRb   = rbLoad & syncNS & syncP;
  end

  // Bit counter in whole frames; cleared while sync is idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      fullFrame <= 1'b0;
    end else if (!active) begin
      bitCnt    <= '0;
      fullFrame <= 1'b0;
    end else if (str.shiftIn) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt    <= '0;
        fullFrame <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // Park sequence: PARK_WORD then NOP_WORD releases the output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      armed      <= 1'b0;
      parked     <= 1'b0;
    end else begin
      frameValid <= str.capture;
      if (str.capture) begin
        if (shiftWord == PARK_WORD) begin
          armed  <= 1'b1;
          parked <= 1'b0;
        end else if (shiftWord == NOP_WORD && armed) begin
          armed  <= 1'b0;
          parked <= 1'b1;
        end else begin
          armed <= 1'b0;
          if (shiftWord != NOP_WORD) parked <= 1'b0;
        end
      end
    end
  end

  assign sdoEnable = ~parked;

endmodule

// File: rtl/spi_cmd_dpath.sv
module spi_cmd_dpath
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             str,
  input  logic               dinBit,
  input  logic [DATA_W-1:0]  rbData,
  output logic [FRAME_W-1:0] shiftWord,
  output logic [FRAME_W-1:0] frameWord,
  output logic               sdoBit
);

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (str.loadRb) begin
      shiftReg <= FRAME_W'(rbData);
    end else if (str.shiftIn) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], dinBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoBit    <= 1'b1;
      frameWord <= '0;
    end else begin
      if (str.shiftOut) sdoBit <= shiftReg[FRAME_W-1];
      if (str.capture)  frameWord <= shiftReg;
    end
  end

  assign shiftWord = shiftReg;

endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               syncNIn,
  input  logic               dinIn,
  input  logic               rbLoad,
  input  logic [DATA_W-1:0]  rbData,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameWord,
  output logic               sdoEnable,
  output logic               sdoPullLow
);

  strobeT str;
  logic dinBit;
  logic sdoBit;
  logic [FRAME_W-1:0] shiftWord;

  spi_cmd_ctrl #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkIn    (sclkIn),
    .syncNIn   (syncNIn),
    .dinIn     (dinIn),
    .rbLoad    (rbLoad),
    .shiftWord (shiftWord),
    .str       (str),
    .dinBit    (dinBit),
    .frameValid(frameValid),
    .sdoEnable (sdoEnable)
  );

  spi_cmd_dpath #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .dinBit   (dinBit),
    .rbData   (rbData),
    .shiftWord(shiftWord),
    .frameWord(frameWord),
    .sdoBit   (sdoBit)
  );

  assign sdoPullLow = sdoEnable & ~sdoBit;

endmodule

// File: rtl/spi_cmd_front_chk.sv
module spi_cmd_front_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameValid,
  input logic [FRAME_W-1:0] frameWord,
  input logic               sdoEnable,
  input logic               sdoPullLow,
  input logic               shiftOut
);

  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> $stable(frameWord));

  // R10
  parked_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEnable |-> !sdoPullLow);

  // R5
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoPullLow) |-> ($past(shiftOut) || !$stable(sdoEnable)));

endmodule

bind spi_cmd_front spi_cmd_front_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameValid(frameValid),
  .frameWord (frameWord),
  .sdoEnable (sdoEnable),
  .sdoPullLow(sdoPullLow),
  .shiftOut  (str.shiftOut)
);

// File: tb/spi_cmd_front_bench.sv
module spi_cmd_front_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic syncN = 1'b1;
  logic din = 1'b0;
  logic rbLoad = 1'b0;
  logic [9:0] rbData = '0;
  logic frameValid;
  logic [15:0] frameWord;
  logic sdoEnable;
  logic sdoPullLow;

  int vecs = 0;
  int errs = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] mShift = '0;
  logic [15:0] mWord = '0;
  bit mArm = 1'b0;
  bit mPark = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_front u_spi_cmd_front (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .syncNIn(syncN), .dinIn(din),
    .rbLoad(rbLoad), .rbData(rbData), .frameValid(frameValid),
    .frameWord(frameWord), .sdoEnable(sdoEnable), .sdoPullLow(sdoPullLow)
  );

  always @(posedge clk) if (frameValid) pulseCnt++;

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doFrame(input int n, input logic [63:0] bits, input bit midRb,
                         input string req);
    int mm = 0;
    int startCnt;
    logic [63:0] got = '0;
    logic [63:0] expS = '0;
    bit acc;
    syncN = 1'b0;
    waitN(4);
    startCnt = pulseCnt;
    for (int i = n - 1; i >= 0; i--) begin
      logic e;
      din = bits[i];
      sclk = 1'b1;
      waitN(4);
      e = mPark ? 1'b1 : mShift[15];
      got[i] = ~sdoPullLow;
      expS[i] = e;
      if (got[i] !== e) mm++;
      mShift = {mShift[14:0], bits[i]};
      if (midRb && i == n / 2) begin
        rbLoad = 1'b1;
        rbData = 10'($urandom);
        @(negedge clk);
        rbLoad = 1'b0;
        sclk = 1'b0;
        waitN(4);
      end else begin
        sclk = 1'b0;
        waitN(4);
      end
    end
    waitN(4);
    syncN = 1'b1;
    waitN(8);
    check(mm == 0, {req, " R5 R10"}, "sdo bits", got, expS);
    acc = (n % 16 == 0) && (n >= 16);
    check((pulseCnt - startCnt) == (acc ? 1 : 0), req, "frameValid pulses",
          64'(pulseCnt - startCnt), acc ? 64'd1 : 64'd0);
    if (acc) begin
      mWord = mShift;
      if (mWord == 16'h8001) begin
        mArm = 1'b1; mPark = 1'b0;
      end else if (mWord == 16'h0000 && mArm) begin
        mArm = 1'b0; mPark = 1'b1;
      end else begin
        mArm = 1'b0;
        if (mWord != 16'h0000) mPark = 1'b0;
      end
    end
    check(frameWord == mWord, req, "frameWord", 64'(frameWord), 64'(mWord));
    check(sdoEnable == !mPark, {req, " R8"}, "sdoEnable", 64'(sdoEnable), 64'(!mPark));
  endtask

  task automatic loadRb(input logic [9:0] d);
    rbData = d;
    rbLoad = 1'b1;
    @(negedge clk);
    rbLoad = 1'b0;
    waitN(2);
    mShift = {6'b0, d};
  endtask

  task automatic idleToggle(input int k);
    logic held;
    int bad = 0;
    held = sdoPullLow;
    for (int i = 0; i < k; i++) begin
      din = 1'($urandom);
      sclk = 1'b1;
      waitN(4);
      if (sdoPullLow !== held) bad++;
      sclk = 1'b0;
      waitN(4);
      if (sdoPullLow !== held) bad++;
    end
    check(bad == 0, "R9", "sdo moved while idle", 64'(bad), 64'd0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    // R1 reset state
    check(frameValid == 1'b0 && frameWord == 16'h0 && sdoEnable == 1'b1 &&
          sdoPullLow == 1'b0, "R1", "reset outputs",
          {44'b0, frameValid, frameWord, sdoEnable, sdoPullLow},
          {44'b0, 1'b0, 16'h0, 1'b1, 1'b0});

    doFrame(16, 64'h1C03, 1'b0, "R2");
    doFrame(16, 64'h0500, 1'b0, "R2");
    doFrame(7, 64'h55, 1'b0, "R3");
    doFrame(32, 64'hA5A5_3C0F, 1'b0, "R4");
    doFrame(31, 64'h1234_5678, 1'b0, "R4");
    doFrame(33, 64'h1_8765_4321, 1'b0, "R4");
    doFrame(17, 64'h1_FFFF, 1'b0, "R4");
    doFrame(32, 64'hBEEF_0C00, 1'b0, "R5");
    doFrame(16, 64'h0000, 1'b0, "R5");
    loadRb(10'h100);
    doFrame(16, 64'h0C00, 1'b0, "R6");
    loadRb(10'h2A5);
    doFrame(16, 64'h1800, 1'b0, "R6");
    doFrame(16, 64'h6F6F, 1'b1, "R7");
    doFrame(16, 64'hF00D, 1'b0, "R7");
    idleToggle(6);
    doFrame(16, 64'h3333, 1'b0, "R9");
    doFrame(16, 64'h8001, 1'b0, "R8");
    doFrame(16, 64'h1234, 1'b0, "R8");
    doFrame(16, 64'h8001, 1'b0, "R8");
    doFrame(16, 64'h0000, 1'b0, "R8");
    doFrame(9, 64'h1AB, 1'b0, "R8");
    doFrame(16, 64'h0000, 1'b0, "R8");
    idleToggle(3);
    doFrame(16, 64'h0C00, 1'b0, "R8");
    doFrame(16, 64'h00FF, 1'b0, "R10");

    for (int it = 0; it < 70; it++) begin
      int sel;
      int n;
      logic [63:0] b;
      sel = int'($urandom % 6);
      b = {$urandom, $urandom};
      case (sel)
        0: n = 16;
        1: n = 32;
        2: n = 1 + int'($urandom % 40);
        3: begin n = 16; b = 64'h8001; end
        4: begin n = 16; b = 64'h0000; end
        default: n = 16 * (1 + int'($urandom % 2));
      endcase
      if ($urandom % 5 == 0) loadRb(10'($urandom));
      doFrame(n, b, ($urandom % 7) == 0, "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule